// File: doc/BRIEF.md
# Processor Power Mode Controller

This block steps a processor among five operating modes: Full-On, Active, Sleep, Deep Sleep and Hibernate. Each mode carries a fixed set of control settings for the PLL (enable and bypass), the core clock, the system clock, core power and the I/O pins. Software moves the block with a one-cycle mode request strobe, with writes to a PLL control word (enable and bypass bits), with writes to a clock multiplier ratio, and with a write of a 2-bit regulator frequency field. A wakeup event and a reset request bring the block out of its low-power modes.

Each exit path depends on the mode. Sleep leaves on wakeup. Deep Sleep and Hibernate leave only on a reset request. On leaving Sleep or Deep Sleep, the stored bypass bit picks Active or Full-On as the next mode. A new multiplier ratio is held as pending and only takes effect on the next entry into Full-On. The block models control behaviour only. It drives enables, not clock gates or regulators.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst` the block is in Full-On (mode code 0): `pll_en_o`=1, `pll_byp_o`=0, both clock enables 1, `core_pwr_o`=1, `io_tri_o`=0, `dma_blk_o`=0, `req_err_o`=0, and `ratio_o` equals the parameter `RATIO_RST`.
- R2: Mode codes are Full-On=0, Active=1, Sleep=2, Deep Sleep=3, Hibernate=4. The output vector {pll_en, pll_byp, cclk, sclk, core_pwr, io_tri, dma_blk} for each mode is:
  - Full-On: 1,0,1,1,1,0,0
  - Active: en,1,1,1,1,0,0
  - Sleep: 1,b,0,1,1,0,1
  - Deep Sleep: 0,b,0,0,1,0,0
  - Hibernate: 0,b,0,0,0,1,0

  Here en is the stored PLL enable bit and b is the stored bypass bit. All outputs update in the same cycle as `mode_o`.
- R3: A request (`req_vld` with 3-bit `req_mode`) is legal in only these cases:
  - from Full-On to 1, 2 or 3;
  - from Active to 3, or to 0 or 2 when the PLL enable bit is set.

  Every other request is ignored, and `req_err_o` pulses high for one cycle, aligned with the cycle in which a legal request would have changed the mode. This covers a request to the current mode, a request with code 5 to 7, and any request made in Sleep, Deep Sleep or Hibernate.
- R4: While in Active with the PLL enable bit cleared, requests for Full-On or Sleep are refused with an error. They succeed once the bit has been written back to 1.
- R5: In Sleep, `wake_i` moves the block to Full-On when the bypass bit is 0, or to Active when it is 1.
- R6: Deep Sleep ignores wakeup, requests and regulator writes. A reset request moves it to Full-On when the bypass bit is 0, or to Active when it is 1.
- R7: A regulator write with `vreg_freq`=2'b00 in Full-On or Active enters Hibernate, and other field values do nothing. Hibernate tri-states the I/O and ignores everything except a reset request, which moves it to Full-On.
- R8: `ratio_wr` is accepted in Full-On and Active only, and updates a pending value. `ratio_o` takes the pending value on entry into Full-On from another mode. A write in the cycle of that entry is applied at once.
- R9: When several events fall in one cycle, the reset request wins, then the Hibernate write, then wakeup, then the mode request. A request that loses to another event raises `req_err_o`.
- R10: PLL control writes are accepted only in Full-On and Active, and the enable field is honoured only in Active. Every entry into Active starts with the enable bit set.
- R11: A reset request in any mode other than Deep Sleep returns the block to Full-On.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_wr | input | 1 | PLL control write strobe |
| pll_wr_en | input | 1 | PLL enable bit written |
| pll_wr_byp | input | 1 | PLL bypass bit written |
| ratio_wr | input | 1 | Multiplier ratio write strobe |
| ratio_wdata | input | RATIO_W | Multiplier ratio value |
| vreg_wr | input | 1 | Regulator control write strobe |
| vreg_freq | input | 2 | Regulator frequency field |
| wake_i | input | 1 | Wakeup event |
| rst_req | input | 1 | Reset request (wakes Deep Sleep and Hibernate) |
| req_vld | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| mode_o | output | 3 | Current mode code |
| pll_en_o | output | 1 | PLL enable |
| pll_byp_o | output | 1 | PLL bypass |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| core_pwr_o | output | 1 | Core power enable |
| io_tri_o | output | 1 | I/O tri-state indication |
| dma_blk_o | output | 1 | Local-memory DMA blocked |
| req_err_o | output | 1 | One-cycle illegal request pulse |
| ratio_o | output | RATIO_W | Multiplier ratio in effect |

## Verification
Several pairs of events can land in the same cycle. The main collisions checked are a mode request against a Hibernate write, against a wakeup, or against a reset request, and a ratio write against the entry into Full-On. The bench drives both strobes on the same falling edge. It then judges the winner by the resulting mode code and by whether `req_err_o` flags the dropped request. For the ratio case it checks whether `ratio_o` shows the value written in that same cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_FULL = 3'd0,
    M_ACT  = 3'd1,
    M_SLP  = 3'd2,
    M_DSLP = 3'd3,
    M_HIB  = 3'd4
  } pmode_e;

  typedef struct packed {
    logic pll_en;
    logic pll_byp;
    logic cclk;
    logic sclk;
    logic pwr;
    logic tri_io;
    logic dma_blk;
  } pcfg_t;

  localparam logic [1:0] HIB_FREQ = 2'b00;
endpackage

// File: rtl/pmc_arbiter.sv
module pmc_arbiter
  import pmc_pkg::*;
(
  input  pmode_e            cur,
  input  logic              en_bit,
  input  logic              byp_bit,
  input  logic              rst_req,
  input  logic              hib_wr,
  input  logic              wake,
  input  logic              req_vld,
  input  logic [MODE_W-1:0] req_mode,
  output pmode_e            nxt,
  output logic              req_err
);
  logic hib_go, wake_go, req_ok;

  function automatic logic legal_move(pmode_e from, logic [MODE_W-1:0] to, logic en);
    logic ok;
    ok = 1'b0;
    case (from)
      M_FULL: ok = (to == M_ACT) || (to == M_SLP) || (to == M_DSLP);
      M_ACT:  ok = (to == M_DSLP) || (en && ((to == M_FULL) || (to == M_SLP)));
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  always_comb begin
    hib_go  = hib_wr && ((cur == M_FULL) || (cur == M_ACT));
    wake_go = wake && (cur == M_SLP);
    req_ok  = req_vld && legal_move(cur, req_mode, en_bit)
              && !rst_req && !hib_go && !wake_go;
    nxt = cur;
    if (rst_req)
      nxt = ((cur == M_DSLP) && byp_bit) ? M_ACT : M_FULL;
    else if (hib_go)
      nxt = M_HIB;
    else if (wake_go)
      nxt = byp_bit ? M_ACT : M_FULL;
    else if (req_ok)
      nxt = pmode_e'(req_mode);
    req_err = req_vld && !req_ok;
  end
endmodule

// File: rtl/pmc_ratio.sv
module pmc_ratio #(
  parameter int RW = 6,
  parameter logic [RW-1:0] RST_VAL = 6'd8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic [RW-1:0] wdata,
  input  logic          enter_full,
  output logic [RW-1:0] active
);
  logic [RW-1:0] pend_q, pend_nxt;

  always_comb pend_nxt = wr_ok ? wdata : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= RST_VAL;
      active <= RST_VAL;
    end else begin
      pend_q <= pend_nxt;
      if (enter_full) active <= pend_nxt;
    end
  end
endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_e nxt,
  input  logic   en_nxt,
  input  logic   byp_nxt,
  output pcfg_t  cfg_q
);
  pcfg_t cfg_d;

  always_comb begin
    case (nxt)
      M_FULL:  cfg_d = '{pll_en:1'b1,   pll_byp:1'b0,    cclk:1'b1, sclk:1'b1, pwr:1'b1, tri_io:1'b0, dma_blk:1'b0};
      M_ACT:   cfg_d = '{pll_en:en_nxt, pll_byp:1'b1,    cclk:1'b1, sclk:1'b1, pwr:1'b1, tri_io:1'b0, dma_blk:1'b0};
      M_SLP:   cfg_d = '{pll_en:1'b1,   pll_byp:byp_nxt, cclk:1'b0, sclk:1'b1, pwr:1'b1, tri_io:1'b0, dma_blk:1'b1};
      M_DSLP:  cfg_d = '{pll_en:1'b0,   pll_byp:byp_nxt, cclk:1'b0, sclk:1'b0, pwr:1'b1, tri_io:1'b0, dma_blk:1'b0};
      default: cfg_d = '{pll_en:1'b0,   pll_byp:byp_nxt, cclk:1'b0, sclk:1'b0, pwr:1'b0, tri_io:1'b1, dma_blk:1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '{pll_en:1'b1, pll_byp:1'b0, cclk:1'b1, sclk:1'b1, pwr:1'b1, tri_io:1'b0, dma_blk:1'b0};
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter logic [RATIO_W-1:0] RATIO_RST = 6'd8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pll_wr,
  input  logic               pll_wr_en,
  input  logic               pll_wr_byp,
  input  logic               ratio_wr,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               vreg_wr,
  input  logic [1:0]         vreg_freq,
  input  logic               wake_i,
  input  logic               rst_req,
  input  logic               req_vld,
  input  logic [2:0]         req_mode,
  output logic [2:0]         mode_o,
  output logic               pll_en_o,
  output logic               pll_byp_o,
  output logic               cclk_en_o,
  output logic               sclk_en_o,
  output logic               core_pwr_o,
  output logic               io_tri_o,
  output logic               dma_blk_o,
  output logic               req_err_o,
  output logic [RATIO_W-1:0] ratio_o
);
  pmode_e mode_q, mode_nxt;
  logic   en_q, en_nxt, byp_q, byp_nxt;
  logic   core_on, err_d, hib_wr;
  pcfg_t  cfg;

  assign core_on = (mode_q == M_FULL) || (mode_q == M_ACT);
  assign hib_wr  = vreg_wr && (vreg_freq == HIB_FREQ);

  pmc_arbiter u_arb (
    .cur     (mode_q),
    .en_bit  (en_q),
    .byp_bit (byp_q),
    .rst_req (rst_req),
    .hib_wr  (hib_wr),
    .wake    (wake_i),
    .req_vld (req_vld),
    .req_mode(req_mode),
    .nxt     (mode_nxt),
    .req_err (err_d)
  );

  always_comb begin
    byp_nxt = (pll_wr && core_on) ? pll_wr_byp : byp_q;
    if (mode_nxt != M_ACT)
      en_nxt = 1'b1;
    else if (pll_wr && (mode_q == M_ACT))
      en_nxt = pll_wr_en;
    else
      en_nxt = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_FULL;
      en_q      <= 1'b1;
      byp_q     <= 1'b0;
      req_err_o <= 1'b0;
    end else begin
      mode_q    <= mode_nxt;
      en_q      <= en_nxt;
      byp_q     <= byp_nxt;
      req_err_o <= err_d;
    end
  end

  pmc_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .nxt    (mode_nxt),
    .en_nxt (en_nxt),
    .byp_nxt(byp_nxt),
    .cfg_q  (cfg)
  );

  pmc_ratio #(.RW(RATIO_W), .RST_VAL(RATIO_RST)) u_ratio (
    .clk       (clk),
    .rst       (rst),
    .wr_ok     (ratio_wr && core_on),
    .wdata     (ratio_wdata),
    .enter_full((mode_nxt == M_FULL) && (mode_q != M_FULL)),
    .active    (ratio_o)
  );

  assign mode_o     = mode_q;
  assign pll_en_o   = cfg.pll_en;
  assign pll_byp_o  = cfg.pll_byp;
  assign cclk_en_o  = cfg.cclk;
  assign sclk_en_o  = cfg.sclk;
  assign core_pwr_o = cfg.pwr;
  assign io_tri_o   = cfg.tri_io;
  assign dma_blk_o  = cfg.dma_blk;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_req,
  input logic          req_vld,
  input logic [2:0]    mode_o,
  input logic          pll_en_o,
  input logic          pll_byp_o,
  input logic          cclk_en_o,
  input logic          sclk_en_o,
  input logic          core_pwr_o,
  input logic          io_tri_o,
  input logic          dma_blk_o,
  input logic          req_err_o,
  input logic [RW-1:0] ratio_o
);
  p_mode_range_r2: assert property (@(posedge clk) disable iff (rst) mode_o <= 3'd4);

  p_fullon_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> (pll_en_o && !pll_byp_o && cclk_en_o && sclk_en_o && core_pwr_o && !io_tri_o && !dma_blk_o));

  p_active_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1) |-> (pll_byp_o && cclk_en_o && sclk_en_o && core_pwr_o && !dma_blk_o));

  p_sleep_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> (dma_blk_o && !cclk_en_o && sclk_en_o && pll_en_o));

  p_tri_only_hib_r7: assert property (@(posedge clk) disable iff (rst)
    io_tri_o |-> ((mode_o == 3'd4) && !core_pwr_o));

  p_hib_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd4) && !rst_req) |=> (mode_o == 3'd4));

  p_dslp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd3) && !rst_req) |=> (mode_o == 3'd3));

  p_err_src_r3: assert property (@(posedge clk) disable iff (rst)
    req_err_o |-> $past(req_vld));

  p_ratio_upd_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_o) |-> ((mode_o == 3'd0) && ($past(mode_o) != 3'd0)));
endmodule

bind pwr_mode_ctrl pmc_checker #(.RW(RATIO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_req   (rst_req),
  .req_vld   (req_vld),
  .mode_o    (mode_o),
  .pll_en_o  (pll_en_o),
  .pll_byp_o (pll_byp_o),
  .cclk_en_o (cclk_en_o),
  .sclk_en_o (sclk_en_o),
  .core_pwr_o(core_pwr_o),
  .io_tri_o  (io_tri_o),
  .dma_blk_o (dma_blk_o),
  .req_err_o (req_err_o),
  .ratio_o   (ratio_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int RW = 6;
  localparam logic [RW-1:0] RRST = 6'd8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_wr = 0, pll_wr_en = 0, pll_wr_byp = 0;
  logic ratio_wr = 0;
  logic [RW-1:0] ratio_wdata = '0;
  logic vreg_wr = 0;
  logic [1:0] vreg_freq = 2'b11;
  logic wake_i = 0, rst_req = 0, req_vld = 0;
  logic [2:0] req_mode = 3'd0;
  logic [2:0] mode_o;
  logic pll_en_o, pll_byp_o, cclk_en_o, sclk_en_o, core_pwr_o, io_tri_o, dma_blk_o, req_err_o;
  logic [RW-1:0] ratio_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.RATIO_W(RW), .RATIO_RST(RRST)) dut_i (
    .clk(clk), .rst(rst), .pll_wr(pll_wr), .pll_wr_en(pll_wr_en), .pll_wr_byp(pll_wr_byp),
    .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata), .vreg_wr(vreg_wr), .vreg_freq(vreg_freq),
    .wake_i(wake_i), .rst_req(rst_req), .req_vld(req_vld), .req_mode(req_mode),
    .mode_o(mode_o), .pll_en_o(pll_en_o), .pll_byp_o(pll_byp_o), .cclk_en_o(cclk_en_o),
    .sclk_en_o(sclk_en_o), .core_pwr_o(core_pwr_o), .io_tri_o(io_tri_o), .dma_blk_o(dma_blk_o),
    .req_err_o(req_err_o), .ratio_o(ratio_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // {pll_en, pll_byp, cclk, sclk, pwr, tri, dma} per R2
  function automatic int exp_cfg(int m, bit en, bit byp);
    case (m)
      0: return 7'b1011100;
      1: return {en, 6'b111100};
      2: return {1'b1, byp, 5'b01101};
      3: return {1'b0, byp, 5'b00100};
      default: return {1'b0, byp, 5'b00010};
    endcase
  endfunction

  function automatic int act_cfg();
    return {pll_en_o, pll_byp_o, cclk_en_o, sclk_en_o, core_pwr_o, io_tri_o, dma_blk_o};
  endfunction

  function automatic bit legal(int m, int c, bit en);
    if (m == 0) return (c == 1) || (c == 2) || (c == 3);
    if (m == 1) return (c == 3) || (en && ((c == 0) || (c == 2)));
    return 1'b0;
  endfunction

  task automatic clr();
    pll_wr = 0; ratio_wr = 0; vreg_wr = 0; wake_i = 0; rst_req = 0; req_vld = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clr();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic req(int c);
    req_vld = 1; req_mode = 3'(c); step();
  endtask

  task automatic pllw(bit en, bit byp);
    pll_wr = 1; pll_wr_en = en; pll_wr_byp = byp; step();
  endtask

  task automatic vreg(logic [1:0] f);
    vreg_wr = 1; vreg_freq = f; step();
  endtask

  task automatic reach(int m);
    do_reset();
    case (m)
      1: req(1);
      2: req(2);
      3: req(3);
      4: vreg(2'b00);
      default: ;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 cfg", act_cfg(), exp_cfg(0, 1, 0));
    chk("R1 err", req_err_o, 0);
    chk("R1 ratio", ratio_o, RRST);

    // R2/R3/R4 sweep: start mode x enable bit x request code
    for (int m = 0; m < 5; m++) begin
      for (int en = 0; en < 2; en++) begin
        for (int c = 0; c < 8; c++) begin
          int em;
          bit een;
          bit ok;
          reach(m);
          chk("R2 start mode", mode_o, m);
          if (m == 1 && en == 0) pllw(0, 0);
          ok = legal(m, c, (m == 1) ? en[0] : 1'b1);
          em = ok ? c : m;
          een = (em == 1 && m == 1) ? en[0] : 1'b1;
          req(c);
          chk($sformatf("R3 mode m%0d c%0d en%0d", m, c, en), mode_o, em);
          chk($sformatf("R3 err m%0d c%0d en%0d", m, c, en), req_err_o, !ok);
          chk($sformatf("R2 cfg m%0d", em), act_cfg(), exp_cfg(em, een, 0));
        end
      end
    end

    // R4: refuse with PLL off, accept after re-enable; error is one cycle
    reach(1);
    pllw(0, 0);
    chk("R4 pll_en off", pll_en_o, 0);
    req(0);
    chk("R4 refused", mode_o, 1);
    chk("R4 err", req_err_o, 1);
    step();
    chk("R3 err one cycle", req_err_o, 0);
    pllw(1, 0);
    req(0);
    chk("R4 accepted", mode_o, 0);

    // R5 Sleep wake with bypass set / cleared
    do_reset(); pllw(0, 1); req(2);
    chk("R2 sleep byp", pll_byp_o, 1);
    wake_i = 1; step();
    chk("R5 wake byp1", mode_o, 1);
    chk("R10 active en set", pll_en_o, 1);
    do_reset(); req(2); wake_i = 1; step();
    chk("R5 wake byp0", mode_o, 0);

    // R6 Deep Sleep
    do_reset(); pllw(0, 1); req(3);
    wake_i = 1; step();
    chk("R6 wake ignored", mode_o, 3);
    req(0);
    chk("R6 req ignored", mode_o, 3);
    vreg(2'b00);
    chk("R6 vreg ignored", mode_o, 3);
    rst_req = 1; step();
    chk("R6 exit byp1", mode_o, 1);
    do_reset(); req(3); rst_req = 1; step();
    chk("R6 exit byp0", mode_o, 0);

    // R7 Hibernate
    do_reset(); vreg(2'b01);
    chk("R7 other freq", mode_o, 0);
    vreg(2'b00);
    chk("R7 enter", mode_o, 4);
    chk("R7 tri", io_tri_o, 1);
    wake_i = 1; step();
    chk("R7 wake ignored", mode_o, 4);
    rst_req = 1; step();
    chk("R7 exit", mode_o, 0);
    chk("R7 tri off", io_tri_o, 0);
    req(1); vreg(2'b00);
    chk("R7 from active", mode_o, 4);

    // R11 reset request from Active and Sleep
    do_reset(); req(1); rst_req = 1; step();
    chk("R11 active", mode_o, 0);
    req(2); rst_req = 1; step();
    chk("R11 sleep", mode_o, 0);

    // R8 ratio pending
    do_reset(); req(1);
    ratio_wr = 1; ratio_wdata = 6'd21; step();
    chk("R8 held", ratio_o, RRST);
    req(0);
    chk("R8 applied", ratio_o, 21);
    req(1);
    ratio_wr = 1; ratio_wdata = 6'd33; req_vld = 1; req_mode = 3'd0; step();
    chk("R8 same cycle", ratio_o, 33);
    req(2);
    ratio_wr = 1; ratio_wdata = 6'd50; step();
    wake_i = 1; step();
    chk("R8 sleep write ignored", ratio_o, 33);
    ratio_wr = 1; ratio_wdata = 6'd5; step();
    chk("R8 no entry in full", ratio_o, 33);

    // R9 same-cycle priority
    do_reset(); req(1);
    vreg_wr = 1; vreg_freq = 2'b00; req_vld = 1; req_mode = 3'd0; step();
    chk("R9 hib over req", mode_o, 4);
    chk("R9 hib err", req_err_o, 1);
    do_reset(); req(2);
    wake_i = 1; req_vld = 1; req_mode = 3'd1; step();
    chk("R9 wake over req", mode_o, 0);
    chk("R9 wake err", req_err_o, 1);
    do_reset();
    rst_req = 1; vreg_wr = 1; vreg_freq = 2'b00; step();
    chk("R9 rstreq over hib", mode_o, 0);
    req(1);
    rst_req = 1; req_vld = 1; req_mode = 3'd3; step();
    chk("R9 rstreq over req", mode_o, 0);
    chk("R9 rstreq err", req_err_o, 1);

    // R10 PLL writes outside Full-On/Active and enable field outside Active
    do_reset(); req(2); pllw(0, 1);
    wake_i = 1; step();
    chk("R10 sleep write ignored", mode_o, 0);
    pllw(0, 0);
    req(1);
    chk("R10 full en ignored", pll_en_o, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule